// File: doc/BRIEF.md
# External Status Latch and Interrupt Request

This block watches the external status sources of one serial channel: a carrier-detect pin and the zero-count flag of the channel's baud-rate counter. While no status interrupt is pending, its status latches are open and follow their inputs. A qualifying event raises a pending status interrupt and freezes the latches. The host then reads a stable snapshot of what caused the interrupt. A one-cycle service strobe clears the pending flag and reopens the latches.

Events that arrive while an interrupt is pending are not lost. Carrier-detect toggles are counted modulo two, so a net change of level is reported again after service and a pulse that returns to the old level is not. A zero-count rise is held over as a deferred request. After service it is honoured only if the flag is still high. The zero-count status bit itself is never latched: it always shows the live flag.

Top module: `est_latch_irq`

## Requirements
- R1: Synchronous active-high reset clears the pending flag, the toggle parity and the deferred request. After reset `irq` is 0 and both latches are open.
- R2: With `dcd_ie`=1 and nothing pending, a level change on `dcd_pin` sets the pending flag on the third rising clock edge after the change (two synchroniser stages and one edge register). At that point `stat_dcd` holds the new level.
- R3: While an interrupt is pending and `dcd_ie`=1, `stat_dcd` keeps the level captured when the latch closed, whatever `dcd_pin` does.
- R4: With `dcd_ie`=0, `stat_dcd` shows the synchronised live pin level two clock edges after a change, and pin changes raise no interrupt.
- R5: With `dcd_ie`=1, an odd number of carrier-detect toggles while an interrupt is pending makes the pending flag rise again one cycle after the service strobe. An even number, including zero, leaves it clear.
- R6: `stat_zc` equals `zc_flag` at all times while `zc_ie`=1, with no latching, and it is 0 while `zc_ie`=0.
- R7: With `zc_ie`=1 and nothing pending, a rising edge of `zc_flag` sets the pending flag on the next clock edge and closes the carrier-detect latch.
- R8: A rising edge of `zc_flag` while an interrupt is pending raises nothing at once. After the service strobe, the flag rises again one cycle later only if `zc_flag` is still 1 at the strobe.
- R9: `svc_done` high for one cycle clears the pending flag at that clock edge. `irq` is 0 in the following cycle, and the latches reopen and follow their inputs.
- R10: `irq` is the pending flag gated by `mie`, active high. The pending flag is kept while `mie`=0 and appears as soon as `mie` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dcd_pin | input | 1 | Raw carrier-detect pin, asynchronous |
| zc_flag | input | 1 | Baud counter at zero |
| dcd_ie | input | 1 | Carrier-detect source enable |
| zc_ie | input | 1 | Zero-count source enable |
| mie | input | 1 | Master status interrupt enable |
| svc_done | input | 1 | One-cycle service-complete strobe |
| stat_dcd | output | 1 | Carrier-detect status bit |
| stat_zc | output | 1 | Zero-count status bit |
| irq | output | 1 | Status interrupt request, active high |

## Verification
The hardest state to reach is the toggle parity built up inside a pending interval, because a pending interrupt masks every single pin change at the ports. The bench raises an interrupt and then applies a swept count of 0 to 4 pin toggles, each held long enough to pass the synchroniser. It then issues the service strobe and checks that `irq` rises again exactly when the count is odd. A second sweep raises a zero-count edge inside a pending interval, then either holds the flag high or drops it before the strobe.

// File: rtl/est_pkg.sv
package est_pkg;
   typedef struct packed {
      logic dcd_edge;   // synchronised carrier-detect changed level
      logic zc_rise;    // zero-count flag went from 0 to 1
   } est_event_t;
endpackage

// File: rtl/est_sync.sv
module est_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= 1'b0;
               else     chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/est_edge.sv
module est_edge
   import est_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       dcd_s,
   input  logic       zc_flag,
   output est_event_t ev
);
   logic dcd_prev;
   logic zc_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         dcd_prev <= 1'b0;
         zc_prev  <= 1'b0;
      end else begin
         dcd_prev <= dcd_s;
         zc_prev  <= zc_flag;
      end
   end

   always_comb begin
      ev.dcd_edge = dcd_s ^ dcd_prev;
      ev.zc_rise  = zc_flag & ~zc_prev;
   end
endmodule

// File: rtl/est_core.sv
module est_core
   import est_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  est_event_t ev,
   input  logic       dcd_s,
   input  logic       zc_flag,
   input  logic       dcd_ie,
   input  logic       zc_ie,
   input  logic       svc_done,
   output logic       pend,
   output logic       lat_dcd
);
   logic par;       // carrier-detect toggles while pending, modulo two
   logic zc_def;    // zero-count rise seen while pending
   logic rearm;     // deferred condition survived service

   logic dcd_ev;
   logic zc_ev;

   always_comb begin
      dcd_ev = ev.dcd_edge & dcd_ie;
      zc_ev  = ev.zc_rise & zc_ie;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend    <= 1'b0;
         par     <= 1'b0;
         zc_def  <= 1'b0;
         rearm   <= 1'b0;
         lat_dcd <= 1'b0;
      end else begin
         rearm <= 1'b0;
         if (svc_done) begin
            pend    <= 1'b0;
            par     <= 1'b0;
            zc_def  <= 1'b0;
            lat_dcd <= dcd_s;
            rearm   <= (par ^ dcd_ev) | ((zc_def | zc_ev) & zc_flag & zc_ie);
         end else if (!pend) begin
            lat_dcd <= dcd_s;
            if (dcd_ev || zc_ev || rearm) pend <= 1'b1;
         end else begin
            if (dcd_ev) par    <= ~par;
            if (zc_ev)  zc_def <= 1'b1;
         end
      end
   end

   // R9: pending flag holds until service
   assert_pend_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (pend && !svc_done) |=> pend);

   // R9: service clears the flag at that edge
   assert_svc_clear_R9: assert property (@(posedge clk) disable iff (rst)
      svc_done |=> !pend);

   // R2: enabled carrier-detect edge raises pending when idle
   assert_dcd_raise_R2: assert property (@(posedge clk) disable iff (rst)
      (!pend && !svc_done && ev.dcd_edge && dcd_ie) |=> pend);

   // R7: enabled zero-count rise raises pending when idle
   assert_zc_raise_R7: assert property (@(posedge clk) disable iff (rst)
      (!pend && !svc_done && ev.zc_rise && zc_ie) |=> pend);

   // R3: latch frozen while pending
   assert_latch_frozen_R3: assert property (@(posedge clk) disable iff (rst)
      (pend && !svc_done) |=> $stable(lat_dcd));
endmodule

// File: rtl/est_latch_irq.sv
module est_latch_irq
   import est_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic dcd_pin,
   input  logic zc_flag,
   input  logic dcd_ie,
   input  logic zc_ie,
   input  logic mie,
   input  logic svc_done,
   output logic stat_dcd,
   output logic stat_zc,
   output logic irq
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic       dcd_s;
   est_event_t ev;
   logic       pend;
   logic       lat_dcd;

   est_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(dcd_pin), .q(dcd_s)
   );

   est_edge u_edge (
      .clk(clk), .rst(rst), .dcd_s(dcd_s), .zc_flag(zc_flag), .ev(ev)
   );

   est_core u_core (
      .clk(clk), .rst(rst), .ev(ev), .dcd_s(dcd_s), .zc_flag(zc_flag),
      .dcd_ie(dcd_ie), .zc_ie(zc_ie), .svc_done(svc_done),
      .pend(pend), .lat_dcd(lat_dcd)
   );

   always_comb begin
      stat_dcd = dcd_ie ? lat_dcd : dcd_s;
      stat_zc  = zc_ie & zc_flag;
      irq      = pend & mie;
   end

   // R10: request never shown while masked
   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
      !mie |-> !irq);

   // R6: zero-count status low whenever the flag is low
   assert_zc_live_R6: assert property (@(posedge clk) disable iff (rst)
      !zc_flag |-> !stat_zc);
endmodule

// File: tb/est_latch_irq_test.sv
module est_latch_irq_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dcd_pin = 1'b0, zc_flag = 1'b0, dcd_ie = 1'b0, zc_ie = 1'b0;
   logic mie = 1'b0, svc_done = 1'b0;
   logic stat_dcd, stat_zc, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic lvl = 1'b0;
   logic cap;

   always #5 clk = ~clk;

   est_latch_irq #(.SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .dcd_pin(dcd_pin), .zc_flag(zc_flag),
      .dcd_ie(dcd_ie), .zc_ie(zc_ie), .mie(mie), .svc_done(svc_done),
      .stat_dcd(stat_dcd), .stat_zc(stat_zc), .irq(irq)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", what, act, exp);
      end
   endtask

   task automatic toggle_pin();
      lvl = ~lvl;
      dcd_pin = lvl;
      tick(4);
   endtask

   task automatic service();
      svc_done = 1'b1;
      tick(1);
      svc_done = 1'b0;
   endtask

   initial begin
      tick(3);
      rst = 1'b0;
      tick(1);
      check("R1 irq after reset", irq, 1'b0);
      check("R1 stat_dcd after reset", stat_dcd, 1'b0);
      check("R1 stat_zc after reset", stat_zc, 1'b0);

      // R4: disabled source is live and silent
      mie = 1'b1;
      lvl = 1'b1; dcd_pin = 1'b1;
      tick(1);
      check("R4 stat_dcd one edge later", stat_dcd, 1'b0);
      tick(1);
      check("R4 stat_dcd two edges later", stat_dcd, 1'b1);
      tick(3);
      check("R4 no irq when disabled", irq, 1'b0);

      // R6: zero-count live bit
      zc_flag = 1'b1; #1;
      check("R6 stat_zc disabled", stat_zc, 1'b0);
      zc_ie = 1'b1; #1;
      check("R6 stat_zc enabled high", stat_zc, 1'b1);
      zc_flag = 1'b0; #1;
      check("R6 stat_zc enabled low", stat_zc, 1'b0);
      tick(2);
      zc_ie = 1'b0;

      // R2 and R5 sweep over toggle counts while pending
      dcd_ie = 1'b1;
      for (int n = 0; n < 5; n++) begin
         lvl = ~lvl; dcd_pin = lvl;
         tick(2);
         check("R2 irq not yet", irq, 1'b0);
         tick(1);
         check("R2 irq raised", irq, 1'b1);
         check("R2 captured level", stat_dcd, lvl);
         cap = lvl;
         for (int k = 0; k < n; k++) toggle_pin();
         check("R3 latched level held", stat_dcd, cap);
         service();
         check("R9 irq clear after service", irq, 1'b0);
         tick(1);
         check("R5 re-raise equals odd count", irq, logic'(n % 2));
         check("R9 latch follows pin", stat_dcd, (n % 2 == 1) ? stat_dcd : lvl);
         if (n % 2 == 1) begin
            service();
            tick(2);
            check("R9 cleared after second service", irq, 1'b0);
         end
         check("R9 latch open shows pin", stat_dcd, lvl);
      end

      // R10: masked pending
      mie = 1'b0;
      lvl = ~lvl; dcd_pin = lvl;
      tick(4);
      check("R10 masked irq", irq, 1'b0);
      mie = 1'b1; #1;
      check("R10 irq on unmask", irq, 1'b1);
      service();
      tick(2);
      check("R10 cleared", irq, 1'b0);

      // R7: zero-count rise raises and closes latch
      zc_ie = 1'b1;
      cap = lvl;
      zc_flag = 1'b1;
      tick(1);
      check("R7 irq on zero-count rise", irq, 1'b1);
      zc_flag = 1'b0;
      lvl = ~lvl; dcd_pin = lvl;
      tick(4);
      check("R7 latch closed by zero-count", stat_dcd, cap);
      lvl = ~lvl; dcd_pin = lvl;
      tick(4);
      service();
      tick(1);
      check("R7 no re-raise on even toggles", irq, 1'b0);

      // R8 sweep: deferred zero-count kept or dropped
      for (int hold = 0; hold < 2; hold++) begin
         lvl = ~lvl; dcd_pin = lvl;
         tick(3);
         check("R8 pending before zero-count", irq, 1'b1);
         zc_flag = 1'b1;
         tick(1);
         if (hold == 0) zc_flag = 1'b0;
         tick(1);
         service();
         check("R8 clear right after service", irq, 1'b0);
         tick(1);
         check("R8 deferred re-raise", irq, logic'(hold));
         if (hold == 1) begin
            service();
            zc_flag = 1'b0;
            tick(2);
            check("R8 cleared after final service", irq, 1'b0);
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule